// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block is a byte-wide configuration register file that sits behind a parallel request channel. That channel is normally driven by a serial slave front end. A small group of chip configuration registers at the bottom of the address space takes effect as soon as it is written. A window of function registers is double-buffered. A host write to the window changes only a pending (shadow) copy. The live (active) copy, which drives the device's control outputs, changes only when the host writes a commit command to a dedicated commit address. At that moment every register in the window is copied from pending to live in a single clock. The commit flag clears itself and is never seen as set.

Requests use a valid/ready channel. The block never applies back-pressure: `req_ready` is held high, so a request is accepted on every clock edge where `req_valid` is high. The read response is a single-cycle strobe. It has no ready, so the host must take `rd_data` in the cycle where `rd_valid` is high. There is only one request port, so a window write and a commit can never be accepted in the same cycle. A commit therefore always includes every window write accepted before it.

Top module: `shadowed_cfg_bank`

## Requirements
- R1: After reset, the pending and live copies of each supported window address a (0x08 to 0x20) both hold (a*0x1D mod 256) AND mask(a). The one exception is address 0x14, which holds 0x01. The configuration registers reset to 0x18 (address 0x00), 0x00 (address 0x01) and 0x05 (address 0x02).
- R2: A write to address 0x00, 0x01 or 0x02 appears on `cfg_vec` bits [8i+7:8i] (i = address) right after the clock edge that accepts it. The written value is ANDed with that register's mask: 0x7E, 0xFF and 0x0F respectively.
- R3: A write to a window address changes only the pending copy. `act_vec` stays unchanged until a commit is accepted.
- R4: A write to address 0xFF with bit 0 set copies every pending window register to `act_vec` at the accepting edge. Window address a maps to `act_vec` bits [8(a-8)+7:8(a-8)]. A write to 0xFF with bit 0 clear has no effect.
- R5: A read of address 0xFF always returns 0x00.
- R6: A read of a window address returns the pending value, not the live value.
- R7: Addresses 0x03 to 0x07, 0x21 to 0xFE, and window addresses whose two low bits are 11 are open. Writes to them change no register, and reads of them return 0x00.
- R8: For a supported window address a, the bit mask is 0xFF shifted right by a[1:0]. Masked bits are dropped on write and read back as 0.
- R9: `rd_valid` is high for exactly one cycle, in the cycle after each accepted read, with `rd_data` valid in that same cycle. It is low otherwise, including during and right after reset.
- R10: `req_ready` is high whenever reset is released, so every request with `req_valid` high is accepted on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (held high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle read response strobe |
| rd_data | output | 8 | Read response data |
| cfg_vec | output | 24 | Immediate configuration registers, 8 bits each |
| act_vec | output | 200 | Live copy of the window, 8 bits per address |

## Verification
On every cycle, the assertions check four things: that `act_vec` holds still unless a commit is accepted, that `cfg_vec` moves only after a write to a configuration address, that `rd_valid` follows accepted reads exactly one cycle later, and that reads of the commit address and the high open range return zero. Some behaviours can only be shown by the bench's sweeps over all 256 addresses, because they depend on stored contents:
- the reset default and mask of each individual address;
- a commit copying the full pending window;
- pending readback diverging from the live copy;
- the final window write before a commit being carried into the live copy.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int BYTE_W = 8;

  // bit mask of a window address; low bits 11 mark an open slot
  function automatic logic [7:0] win_mask(input logic [7:0] a);
    return (a[1:0] == 2'b11) ? 8'h00 : (8'hFF >> a[1:0]);
  endfunction

  function automatic logic [7:0] win_dflt(input logic [7:0] a);
    logic [7:0] prod;
    prod = a * 8'h1D;
    return (a == 8'h14) ? 8'h01 : (prod & win_mask(a));
  endfunction

  function automatic logic [7:0] cfg_mask(input int i);
    case (i)
      0: return 8'h7E;
      1: return 8'hFF;
      2: return 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] cfg_dflt(input int i);
    case (i)
      0: return 8'h18;
      2: return 8'h05;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/scb_decode.sv
module scb_decode #(
  parameter int          CFG_N = 3,
  parameter logic [7:0]  WIN_LO = 8'h08,
  parameter logic [7:0]  WIN_HI = 8'h20,
  parameter logic [7:0]  XFER_ADDR = 8'hFF,
  localparam int         NSH = int'(WIN_HI) - int'(WIN_LO) + 1,
  localparam int         WI_W = $clog2(NSH),
  localparam int         CI_W = (CFG_N > 1) ? $clog2(CFG_N) : 1
) (
  input  logic [7:0]      addr,
  output logic            is_cfg,
  output logic            is_win,
  output logic            is_xfer,
  output logic [CI_W-1:0] cfg_idx,
  output logic [WI_W-1:0] win_idx
);
  logic [7:0] woff;
  assign woff    = addr - WIN_LO;
  assign is_cfg  = (addr < 8'(CFG_N));
  assign is_win  = (addr >= WIN_LO) && (addr <= WIN_HI);
  assign is_xfer = (addr == XFER_ADDR);
  assign cfg_idx = CI_W'(addr);
  assign win_idx = WI_W'(woff);
endmodule

// File: rtl/scb_cell.sv
module scb_cell
  import scb_pkg::*;
#(
  parameter logic [7:0] ADDR = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       commit,
  output logic [7:0] shadow,
  output logic [7:0] active
);
  localparam logic [7:0] MASK = win_mask(ADDR);
  localparam logic [7:0] DFLT = win_dflt(ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= DFLT;
      active <= DFLT;
    end else begin
      if (wr_en)  shadow <= wdata & MASK;
      if (commit) active <= shadow;
    end
  end
endmodule

// File: rtl/scb_rdmux.sv
module scb_rdmux #(
  parameter int CFG_N = 3,
  parameter int NSH   = 25,
  localparam int WI_W = $clog2(NSH),
  localparam int CI_W = (CFG_N > 1) ? $clog2(CFG_N) : 1
) (
  input  logic               is_cfg,
  input  logic               is_win,
  input  logic [CI_W-1:0]    cfg_idx,
  input  logic [WI_W-1:0]    win_idx,
  input  logic [CFG_N*8-1:0] cfg_vec,
  input  logic [NSH*8-1:0]   shd_vec,
  output logic [7:0]         dout
);
  always_comb begin
    dout = 8'h00;
    if (is_cfg) begin
      for (int i = 0; i < CFG_N; i++)
        if (cfg_idx == CI_W'(i)) dout = cfg_vec[i*8 +: 8];
    end else if (is_win) begin
      for (int k = 0; k < NSH; k++)
        if (win_idx == WI_W'(k)) dout = shd_vec[k*8 +: 8];
    end
  end
endmodule

// File: rtl/shadowed_cfg_bank.sv
module shadowed_cfg_bank
  import scb_pkg::*;
#(
  parameter int          CFG_N = 3,
  parameter logic [7:0]  WIN_LO = 8'h08,
  parameter logic [7:0]  WIN_HI = 8'h20,
  parameter logic [7:0]  XFER_ADDR = 8'hFF,
  localparam int         NSH = int'(WIN_HI) - int'(WIN_LO) + 1,
  localparam int         WI_W = $clog2(NSH),
  localparam int         CI_W = (CFG_N > 1) ? $clog2(CFG_N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [7:0]         req_addr,
  input  logic [7:0]         req_wdata,
  output logic               rd_valid,
  output logic [7:0]         rd_data,
  output logic [CFG_N*8-1:0] cfg_vec,
  output logic [NSH*8-1:0]   act_vec
);
  logic            is_cfg, is_win, is_xfer;
  logic [CI_W-1:0] cfg_idx;
  logic [WI_W-1:0] win_idx;
  logic            fire, wr, rd, commit;
  logic [NSH*8-1:0] shd_vec;
  logic [7:0]      rd_next;

  assign req_ready = rst_n;
  assign fire   = req_valid && req_ready;
  assign wr     = fire && req_write;
  assign rd     = fire && !req_write;
  assign commit = wr && is_xfer && req_wdata[0];

  scb_decode #(.CFG_N(CFG_N), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .XFER_ADDR(XFER_ADDR)) u_dec (
    .addr(req_addr), .is_cfg(is_cfg), .is_win(is_win), .is_xfer(is_xfer),
    .cfg_idx(cfg_idx), .win_idx(win_idx)
  );

  // immediate configuration registers
  for (genvar i = 0; i < CFG_N; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_vec[i*8 +: 8] <= cfg_dflt(i);
      else if (wr && is_cfg && cfg_idx == CI_W'(i))
        cfg_vec[i*8 +: 8] <= req_wdata & cfg_mask(i);
    end
  end

  // double-buffered window
  for (genvar k = 0; k < NSH; k++) begin : g_win
    scb_cell #(.ADDR(WIN_LO + 8'(k))) u_cell (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr && is_win && win_idx == WI_W'(k)),
      .wdata(req_wdata), .commit(commit),
      .shadow(shd_vec[k*8 +: 8]), .active(act_vec[k*8 +: 8])
    );
  end

  scb_rdmux #(.CFG_N(CFG_N), .NSH(NSH)) u_mux (
    .is_cfg(is_cfg), .is_win(is_win), .cfg_idx(cfg_idx), .win_idx(win_idx),
    .cfg_vec(cfg_vec), .shd_vec(shd_vec), .dout(rd_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= rd;
      if (rd) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/scb_chk.sv
module scb_chk #(
  parameter int         CFG_N = 3,
  parameter logic [7:0] WIN_HI = 8'h20,
  parameter logic [7:0] XFER_ADDR = 8'hFF,
  parameter int         NSH = 25
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [7:0]         req_addr,
  input logic [7:0]         req_wdata,
  input logic               rd_valid,
  input logic [7:0]         rd_data,
  input logic [CFG_N*8-1:0] cfg_vec,
  input logic [NSH*8-1:0]   act_vec
);
  logic acc, cmt, rdq, cfgw;
  assign acc  = req_valid && req_ready;
  assign cmt  = acc && req_write && (req_addr == XFER_ADDR) && req_wdata[0];
  assign rdq  = acc && !req_write;
  assign cfgw = acc && req_write && (req_addr < 8'(CFG_N));

  // R3
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !cmt |=> $stable(act_vec));
  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !cfgw |=> $stable(cfg_vec));
  // R9
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n) rdq |=> rd_valid);
  // R9
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !rdq |=> !rd_valid);
  // R5
  xfer_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdq && req_addr == XFER_ADDR) |=> (rd_data == 8'h00));
  // R7
  open_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdq && req_addr > WIN_HI && req_addr != XFER_ADDR) |=> (rd_data == 8'h00));
endmodule

bind shadowed_cfg_bank scb_chk #(.CFG_N(CFG_N), .WIN_HI(WIN_HI), .XFER_ADDR(XFER_ADDR), .NSH(NSH)) u_chk (.*);

// File: tb/sim_shadowed_cfg_bank.sv
module sim_shadowed_cfg_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NSH = 25;
  localparam int WATCHDOG = 20000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = 0, req_wdata = 0;
  logic req_ready, rd_valid;
  logic [7:0] rd_data;
  logic [23:0] cfg_vec;
  logic [NSH*8-1:0] act_vec;
  int total = 0, bad = 0;
  bit done = 0;

  shadowed_cfg_bank u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] e_mask(input int a);
    if (a <= 2) return (a == 0) ? 8'h7E : (a == 1) ? 8'hFF : 8'h0F;
    if (a < 8 || a > 32 || (a % 4) == 3) return 8'h00;
    return 8'(255 >> (a % 4));
  endfunction

  function automatic logic [7:0] e_dflt(input int a);
    if (a == 0) return 8'h18;
    if (a == 2) return 8'h05;
    if (a == 20) return 8'h01;
    if (a < 8 || a > 32) return 8'h00;
    return 8'((a * 29) % 256) & e_mask(a);
  endfunction

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'(a * 7 + seed) ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input int a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic do_read(input int a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 8'(a);
    chk(req_ready === 1'b1, "R10 ready", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 0;
    chk(rd_valid === 1'b1, "R9 strobe", int'(rd_valid), 1);
    d = rd_data;
    @(negedge clk);
    chk(rd_valid === 1'b0, "R9 single", int'(rd_valid), 0);
  endtask

  task automatic chk_act(input string req, input int seed, input bit use_dflt);
    for (int a = 8; a <= 32; a++) begin
      logic [7:0] e;
      e = use_dflt ? e_dflt(a) : (pat(a, seed) & e_mask(a));
      chk(act_vec[(a-8)*8 +: 8] == e, req, int'(act_vec[(a-8)*8 +: 8]), int'(e));
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk(rd_valid === 1'b0, "R9 reset", int'(rd_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(rd_valid === 1'b0, "R9 after reset", int'(rd_valid), 0);
    // R1: reset defaults on outputs
    for (int i = 0; i < 3; i++)
      chk(cfg_vec[i*8 +: 8] == e_dflt(i), "R1 cfg", int'(cfg_vec[i*8 +: 8]), int'(e_dflt(i)));
    chk_act("R1 live", 0, 1);
    chk(act_vec[(20-8)*8 +: 8] == 8'h01, "R1 0x14", int'(act_vec[(20-8)*8 +: 8]), 1);
    // R1/R7: read sweep of defaults
    for (int a = 0; a < 256; a++) begin
      do_read(a, d);
      chk(d == e_dflt(a), "R1 R7 read default", int'(d), int'(e_dflt(a)));
    end
    // write sweep, commit address excluded
    for (int a = 0; a < 255; a++) do_write(a, pat(a, 0));
    for (int i = 0; i < 3; i++)
      chk(cfg_vec[i*8 +: 8] == (pat(i, 0) & e_mask(i)), "R2 cfg write",
          int'(cfg_vec[i*8 +: 8]), int'(pat(i, 0) & e_mask(i)));
    chk_act("R3 live held", 0, 1);
    // R6 R7 R8: pending readback with masks
    for (int a = 0; a < 256; a++) begin
      do_read(a, d);
      chk(d == (pat(a, 0) & e_mask(a)), "R6 R7 R8 readback", int'(d), int'(pat(a, 0) & e_mask(a)));
    end
    // R4: bit 0 clear does nothing
    do_write(255, 8'hFE);
    chk_act("R4 no commit", 0, 1);
    // R4: commit copies whole window
    do_write(255, 8'h01);
    chk_act("R4 commit", 0, 0);
    do_read(255, d);
    chk(d == 8'h00, "R5 xfer read", int'(d), 0);
    // second round: pending diverges, last write right before commit
    for (int a = 8; a <= 32; a++) do_write(a, pat(a, 3));
    for (int a = 8; a <= 32; a += 5) begin
      do_read(a, d);
      chk(d == (pat(a, 3) & e_mask(a)), "R6 pending", int'(d), int'(pat(a, 3) & e_mask(a)));
    end
    chk_act("R3 live old", 0, 0);
    do_write(255, 8'hFF);
    chk_act("R4 commit second", 3, 0);
    do_read(255, d);
    chk(d == 8'h00, "R5 after commit", int'(d), 0);
    // R7: open writes did not disturb cfg
    for (int i = 0; i < 3; i++)
      chk(cfg_vec[i*8 +: 8] == (pat(i, 0) & e_mask(i)), "R7 cfg intact",
          int'(cfg_vec[i*8 +: 8]), int'(pat(i, 0) & e_mask(i)));
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule